// File: doc/BRIEF.md
# Nametable Slot Router

This block sits between a video processor's nametable bus and the storage behind it. The nametable window is split into four 1 KiB slots. A small mapping register gives each slot one of four backing sources: console VRAM page 0, console VRAM page 1, an on-chip 1 KiB auxiliary RAM, or a synthesized fill pattern. For every video access, the block decodes the address into a slot and an offset. For VRAM slots it emits a page select and offset toward the console VRAM. For the other two sources it returns the byte itself. Writes aimed at non-VRAM slots never reach the console VRAM.

The same auxiliary RAM is also visible to the CPU through a 1 KiB window. A 2-bit auxiliary-mode register controls who may use it. The video side may read and write it only in modes 0 and 1. The CPU may write it in modes 0, 1 and 2, and may read it in every mode. The fill source returns a programmable tile byte for name entries and a replicated palette byte for attribute entries.

The video and CPU paths are combinational lookups that are ready in every cycle. They have no back-pressure: a request strobe is qualified by the matching `*_rvalid` or `vram_req` output in the same cycle. Register writes take effect at the next clock edge. CPU and video never touch the auxiliary RAM in the same cycle. If they did, the CPU write would take priority.

Top module: `nt_slot_router`

## Requirements
- R1: The mapping register holds 2 bits per slot, with slot k in bits 2k+1:2k. Code 0 routes to VRAM page 0 and code 1 routes to VRAM page 1. For these codes `vram_req` is high, `vram_page` equals the code and `vid_rvalid` is low.
- R2: The slot is bits 11:10 of (video address − 0x2000), and the offset is the low 10 bits. For example, 0x3405 is slot 1, offset 0x005. While `vram_req` is low, `vram_page` and `vram_off` are zero.
- R3: For a fill slot (code 3), offsets 0x3C0 and above return the fill attribute byte. Lower offsets return the fill tile byte.
- R4: The fill colour register keeps only bits 1:0 (p). The attribute byte is p replicated into all four 2-bit fields: p=2 gives 0xAA and p=1 gives 0x55.
- R5: An auxiliary RAM slot (code 2) returns the RAM byte at the offset while the mode is 0 or 1. In modes 2 and 3 it returns 0x00 with `vid_rvalid` high.
- R6: A video write to a code-2 slot is stored in RAM only in modes 0 and 1. It never raises `vram_req` or `vram_we`.
- R7: A video write to a fill slot is discarded. It does not reach VRAM, and later fill reads are unchanged.
- R8: The CPU reads and writes the RAM at 0x5C00–0x5FFF. CPU writes are accepted in modes 0, 1 and 2 and ignored in mode 3.
- R9: The mode register at 0x5104 keeps bits 1:0 and reads them back, so writing 0xFF reads back 0x03. The mapping register is at 0x5105, the fill tile at 0x5106 and the fill colour at 0x5107.
- R10: A register write changes routing only from the cycle after its clock edge. A video lookup in the same cycle as the write uses the old setting.
- R11: After reset the mapping register, mode, fill tile and fill colour are all zero, so every slot routes to VRAM page 0.
- R12: `cpu_rvalid` is high only for a CPU read of the RAM window or the mode register. Otherwise `cpu_rvalid` is low and `cpu_rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, zero unless valid |
| cpu_rvalid | output | 1 | CPU read hit a readable location |
| vid_rd | input | 1 | Video read strobe |
| vid_wr | input | 1 | Video write strobe |
| vid_addr | input | 14 | Video nametable address |
| vid_wdata | input | 8 | Video write data |
| vid_rdata | output | 8 | Byte returned for RAM/fill slots, zero otherwise |
| vid_rvalid | output | 1 | Video read served by this block |
| vram_req | output | 1 | Access is forwarded to console VRAM |
| vram_we | output | 1 | Forwarded access is a write |
| vram_page | output | 1 | Console VRAM page select |
| vram_off | output | 10 | Offset within the selected page |

## Verification
A CPU write to the mapping register and a video lookup can land in the same cycle. This is the one place where the register path and the combinational routing path interact. The bench provokes it by remapping slot 0 from page 1 to page 0 while a video read of that slot is already on the bus. The same-cycle result must still show page 1, and a read one cycle later must show page 0. Both results are queued as expected items and compared by the monitor at the falling edge.

// File: rtl/nt_route_pkg.sv
package nt_route_pkg;
  typedef enum logic [1:0] {
    SRC_PAGE0 = 2'd0,
    SRC_PAGE1 = 2'd1,
    SRC_XRAM  = 2'd2,
    SRC_FILL  = 2'd3
  } nt_src_e;

  function automatic logic [7:0] spread_palette(input logic [1:0] p);
    return {4{p}};
  endfunction

  function automatic logic video_may_use_xram(input logic [1:0] mode);
    return (mode == 2'd0) || (mode == 2'd1);
  endfunction

  function automatic logic cpu_may_write_xram(input logic [1:0] mode);
    return mode != 2'd3;
  endfunction
endpackage

// File: rtl/nt_addr_decode.sv
module nt_addr_decode
  import nt_route_pkg::*;
#(
  parameter int VA_W       = 14,
  parameter int NT_BASE    = 'h2000,
  parameter int SLOTS      = 4,
  parameter int SLOT_BYTES = 1024,
  localparam int OFF_W     = $clog2(SLOT_BYTES),
  localparam int SLOT_W    = $clog2(SLOTS)
) (
  input  logic [VA_W-1:0]    vid_addr,
  input  logic [2*SLOTS-1:0] map,
  output logic [SLOT_W-1:0]  slot,
  output logic [OFF_W-1:0]   offset,
  output nt_src_e            src
);
  logic [VA_W-1:0] rel;
  nt_src_e codes [SLOTS];

  assign rel    = vid_addr - VA_W'(NT_BASE);
  assign slot   = rel[OFF_W +: SLOT_W];
  assign offset = rel[OFF_W-1:0];

  for (genvar g = 0; g < SLOTS; g++) begin : g_code
    assign codes[g] = nt_src_e'(map[2*g +: 2]);
  end

  assign src = codes[slot];
endmodule

// File: rtl/nt_cfg_regs.sv
module nt_cfg_regs #(
  parameter int CA_W        = 16,
  parameter int DATA_W      = 8,
  parameter int SLOTS       = 4,
  parameter int MODE_ADDR   = 'h5104,
  parameter int MAP_ADDR    = 'h5105,
  parameter int TILE_ADDR   = 'h5106,
  parameter int COLOUR_ADDR = 'h5107
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_wr,
  input  logic [CA_W-1:0]    cpu_addr,
  input  logic [DATA_W-1:0]  cpu_wdata,
  output logic [2*SLOTS-1:0] map_q,
  output logic [DATA_W-1:0]  tile_q,
  output logic [1:0]         pal_q,
  output logic [1:0]         mode_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_q  <= '0;
      tile_q <= '0;
      pal_q  <= '0;
      mode_q <= '0;
    end else if (cpu_wr) begin
      if (cpu_addr == CA_W'(MODE_ADDR))   mode_q <= cpu_wdata[1:0];
      if (cpu_addr == CA_W'(MAP_ADDR))    map_q  <= (2*SLOTS)'(cpu_wdata);
      if (cpu_addr == CA_W'(TILE_ADDR))   tile_q <= cpu_wdata;
      if (cpu_addr == CA_W'(COLOUR_ADDR)) pal_q  <= cpu_wdata[1:0];
    end
  end
endmodule

// File: rtl/nt_xram.sv
module nt_xram #(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr_v,
  output logic [DATA_W-1:0] rdata_v,
  input  logic [AW-1:0]     raddr_c,
  output logic [DATA_W-1:0] rdata_c
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_v = mem[raddr_v];
  assign rdata_c = mem[raddr_c];
endmodule

// File: rtl/nt_slot_router.sv
module nt_slot_router
  import nt_route_pkg::*;
#(
  parameter int CA_W          = 16,
  parameter int VA_W          = 14,
  parameter int DATA_W        = 8,
  parameter int SLOTS         = 4,
  parameter int SLOT_BYTES    = 1024,
  parameter int NT_BASE       = 'h2000,
  parameter int XRAM_BASE     = 'h5C00,
  parameter int FILL_ATTR_OFF = 'h3C0,
  parameter int MODE_ADDR     = 'h5104,
  parameter int MAP_ADDR      = 'h5105,
  parameter int TILE_ADDR     = 'h5106,
  parameter int COLOUR_ADDR   = 'h5107,
  localparam int OFF_W        = $clog2(SLOT_BYTES),
  localparam int SLOT_W       = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [CA_W-1:0]   cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_rvalid,
  input  logic              vid_rd,
  input  logic              vid_wr,
  input  logic [VA_W-1:0]   vid_addr,
  input  logic [DATA_W-1:0] vid_wdata,
  output logic [DATA_W-1:0] vid_rdata,
  output logic              vid_rvalid,
  output logic              vram_req,
  output logic              vram_we,
  output logic              vram_page,
  output logic [OFF_W-1:0]  vram_off
);
  logic [2*SLOTS-1:0] map_q;
  logic [DATA_W-1:0]  tile_q;
  logic [1:0]         pal_q;
  logic [1:0]         mode_q;
  logic [SLOT_W-1:0]  slot;
  logic [OFF_W-1:0]   offset;
  nt_src_e            src;
  logic               is_vram;
  logic [DATA_W-1:0]  ram_v, ram_c, lookup;
  logic               cpu_xram_hit, cpu_mode_hit;
  logic               cpu_we_x, vid_we_x;

  nt_cfg_regs #(
    .CA_W(CA_W), .DATA_W(DATA_W), .SLOTS(SLOTS), .MODE_ADDR(MODE_ADDR),
    .MAP_ADDR(MAP_ADDR), .TILE_ADDR(TILE_ADDR), .COLOUR_ADDR(COLOUR_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .map_q(map_q), .tile_q(tile_q), .pal_q(pal_q),
    .mode_q(mode_q)
  );

  nt_addr_decode #(
    .VA_W(VA_W), .NT_BASE(NT_BASE), .SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES)
  ) u_dec (
    .vid_addr(vid_addr), .map(map_q), .slot(slot), .offset(offset), .src(src)
  );

  // auxiliary RAM window and write arbitration (CPU first)
  assign cpu_xram_hit = cpu_addr[CA_W-1:OFF_W] == XRAM_BASE[CA_W-1:OFF_W];
  assign cpu_mode_hit = cpu_addr == CA_W'(MODE_ADDR);
  assign cpu_we_x     = cpu_wr && cpu_xram_hit && cpu_may_write_xram(mode_q);
  assign vid_we_x     = vid_wr && (src == SRC_XRAM) && video_may_use_xram(mode_q);

  nt_xram #(.DEPTH(SLOT_BYTES), .DATA_W(DATA_W)) u_xram (
    .clk(clk),
    .we(cpu_we_x || vid_we_x),
    .waddr(cpu_we_x ? cpu_addr[OFF_W-1:0] : offset),
    .wdata(cpu_we_x ? cpu_wdata : vid_wdata),
    .raddr_v(offset), .rdata_v(ram_v),
    .raddr_c(cpu_addr[OFF_W-1:0]), .rdata_c(ram_c)
  );

  // video routing
  assign is_vram = (src == SRC_PAGE0) || (src == SRC_PAGE1);

  always_comb begin
    unique case (src)
      SRC_XRAM: lookup = video_may_use_xram(mode_q) ? ram_v : '0;
      SRC_FILL: lookup = (offset >= OFF_W'(FILL_ATTR_OFF))
                         ? DATA_W'(spread_palette(pal_q)) : tile_q;
      default:  lookup = '0;
    endcase
  end

  assign vram_req   = (vid_rd || vid_wr) && is_vram;
  assign vram_we    = vid_wr && is_vram;
  assign vram_page  = vram_req && (src == SRC_PAGE1);
  assign vram_off   = vram_req ? offset : '0;
  assign vid_rvalid = vid_rd && !is_vram;
  assign vid_rdata  = vid_rvalid ? lookup : '0;

  // CPU read path
  assign cpu_rvalid = cpu_rd && (cpu_xram_hit || cpu_mode_hit);
  assign cpu_rdata  = !cpu_rvalid ? '0
                    : cpu_xram_hit ? ram_c : DATA_W'(mode_q);
endmodule

// File: rtl/nt_slot_router_chk.sv
module nt_slot_router_chk #(
  parameter int CA_W          = 16,
  parameter int VA_W          = 14,
  parameter int DATA_W        = 8,
  parameter int SLOTS         = 4,
  parameter int SLOT_BYTES    = 1024,
  parameter int NT_BASE       = 'h2000,
  parameter int FILL_ATTR_OFF = 'h3C0,
  parameter int MODE_ADDR     = 'h5104,
  parameter int MAP_ADDR      = 'h5105,
  localparam int OFF_W        = $clog2(SLOT_BYTES),
  localparam int SLOT_W       = $clog2(SLOTS)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cpu_wr,
  input logic               cpu_rd,
  input logic [CA_W-1:0]    cpu_addr,
  input logic [DATA_W-1:0]  cpu_wdata,
  input logic               cpu_rvalid,
  input logic               vid_rd,
  input logic               vid_wr,
  input logic [VA_W-1:0]    vid_addr,
  input logic [DATA_W-1:0]  vid_rdata,
  input logic               vid_rvalid,
  input logic               vram_req,
  input logic               vram_we,
  input logic [2*SLOTS-1:0] map_q,
  input logic [1:0]         mode_q
);
  logic [VA_W-1:0]   rel;
  logic [SLOT_W-1:0] slot;
  logic [1:0]        code;

  assign rel  = vid_addr - VA_W'(NT_BASE);
  assign slot = rel[OFF_W +: SLOT_W];
  assign code = map_q[2*slot +: 2];

  p_route_vram_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_rd && code < 2'd2) |-> (vram_req && !vid_rvalid));

  p_one_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(vram_req && vid_rvalid));

  p_fill_attr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_rd && code == 2'd3 && rel[OFF_W-1:0] >= OFF_W'(FILL_ATTR_OFF))
      |-> (vid_rdata == {4{vid_rdata[1:0]}}));

  p_xram_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_rd && code == 2'd2 && mode_q[1]) |-> (vid_rvalid && vid_rdata == '0));

  p_no_leak_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_wr && code == 2'd2) |-> (!vram_req && !vram_we));

  p_fill_swallow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_wr && code == 2'd3) |-> (!vram_req && !vram_we));

  p_mode_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == CA_W'(MODE_ADDR)) |=> (mode_q == $past(cpu_wdata[1:0])));

  p_map_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_wr && cpu_addr == CA_W'(MAP_ADDR)) |=> $stable(map_q));

  p_rvalid_qual_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rvalid |-> cpu_rd);
endmodule

bind nt_slot_router nt_slot_router_chk #(
  .CA_W(CA_W), .VA_W(VA_W), .DATA_W(DATA_W), .SLOTS(SLOTS),
  .SLOT_BYTES(SLOT_BYTES), .NT_BASE(NT_BASE), .FILL_ATTR_OFF(FILL_ATTR_OFF),
  .MODE_ADDR(MODE_ADDR), .MAP_ADDR(MAP_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
  .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rvalid(cpu_rvalid),
  .vid_rd(vid_rd), .vid_wr(vid_wr), .vid_addr(vid_addr),
  .vid_rdata(vid_rdata), .vid_rvalid(vid_rvalid), .vram_req(vram_req),
  .vram_we(vram_we), .map_q(map_q), .mode_q(mode_q)
);

// File: tb/nt_slot_router_bench.sv
module nt_slot_router_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        cpu_rvalid;
  logic        vid_rd = 1'b0, vid_wr = 1'b0;
  logic [13:0] vid_addr = '0;
  logic [7:0]  vid_wdata = '0;
  logic [7:0]  vid_rdata;
  logic        vid_rvalid, vram_req, vram_we, vram_page;
  logic [9:0]  vram_off;

  always #4 clk = ~clk;

  nt_slot_router u_nt_slot_router (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_rvalid(cpu_rvalid), .vid_rd(vid_rd), .vid_wr(vid_wr),
    .vid_addr(vid_addr), .vid_wdata(vid_wdata), .vid_rdata(vid_rdata),
    .vid_rvalid(vid_rvalid), .vram_req(vram_req), .vram_we(vram_we),
    .vram_page(vram_page), .vram_off(vram_off)
  );

  // scoreboard
  logic [21:0] exp_q[$];
  bit          kind_q[$];
  string       tag_q[$];
  bit          mon_go = 1'b0;
  bit          mon_kind = 1'b0;
  int          n_cmp = 0, n_bad = 0;
  bit          finished = 1'b0;

  localparam logic [15:0] A_MODE = 16'h5104, A_MAP = 16'h5105,
                          A_TILE = 16'h5106, A_COL = 16'h5107;

  function automatic logic [21:0] vw(bit we, bit req, bit pg, logic [9:0] off,
                                     bit rv, logic [7:0] d);
    return {we, req, pg, off, rv, d};
  endfunction
  function automatic logic [21:0] cw(bit rv, logic [7:0] d);
    return {13'd0, rv, d};
  endfunction

  always @(negedge clk) begin
    if (mon_go && exp_q.size() > 0) begin
      logic [21:0] obs, expv;
      bit k;
      string t;
      expv = exp_q.pop_front();
      k = kind_q.pop_front();
      t = tag_q.pop_front();
      obs = k ? cw(cpu_rvalid, cpu_rdata)
              : vw(vram_we, vram_req, vram_page, vram_off, vid_rvalid, vid_rdata);
      n_cmp++;
      if (obs !== expv) begin
        n_bad++;
        $display("FAIL %s: actual %06h expected %06h", t, obs, expv);
      end
    end
  end

  task automatic push(bit k, logic [21:0] e, string t);
    exp_q.push_back(e); kind_q.push_back(k); tag_q.push_back(t);
    mon_go = 1'b1;
  endtask

  task automatic finish_cycle();
    @(posedge clk); #1;
    cpu_wr = 0; cpu_rd = 0; vid_rd = 0; vid_wr = 0; mon_go = 1'b0;
  endtask

  task automatic cpu_write(logic [15:0] a, logic [7:0] d);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1;
    finish_cycle();
  endtask

  task automatic cpu_read(logic [15:0] a, logic [21:0] e, string t);
    cpu_addr = a; cpu_rd = 1; push(1'b1, e, t);
    finish_cycle();
  endtask

  task automatic vid_read(logic [13:0] a, logic [21:0] e, string t);
    vid_addr = a; vid_rd = 1; push(1'b0, e, t);
    finish_cycle();
  endtask

  task automatic vid_write(logic [13:0] a, logic [7:0] d, logic [21:0] e, string t);
    vid_addr = a; vid_wdata = d; vid_wr = 1; push(1'b0, e, t);
    finish_cycle();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R11: reset routing and mode
    vid_read(14'h2000, vw(0,1,0,10'h000,0,0), "R11");
    vid_read(14'h2400, vw(0,1,0,10'h000,0,0), "R11");
    vid_read(14'h2800, vw(0,1,0,10'h000,0,0), "R11");
    vid_read(14'h2C00, vw(0,1,0,10'h000,0,0), "R11");
    cpu_read(A_MODE, cw(1, 8'h00), "R11");

    // R9: mode keeps two bits
    cpu_write(A_MODE, 8'hFF);
    cpu_read(A_MODE, cw(1, 8'h03), "R9");
    cpu_write(A_MODE, 8'h00);

    // R1/R2: slot0=page1, slot1=page0, slot2=aux RAM, slot3=fill
    cpu_write(A_MAP, 8'hE1);
    vid_read(14'h2005, vw(0,1,1,10'h005,0,0), "R1");
    vid_read(14'h27FF, vw(0,1,0,10'h3FF,0,0), "R1");
    vid_read(14'h3405, vw(0,1,0,10'h005,0,0), "R2");
    vid_write(14'h2011, 8'h42, vw(1,1,1,10'h011,0,0), "R2");

    // R8: CPU access to aux RAM, mode 0
    cpu_write(16'h5C10, 8'h5A);
    cpu_write(16'h5FFF, 8'hC3);
    cpu_write(16'h5C21, 8'h11);
    cpu_write(16'h5C30, 8'h44);
    cpu_read(16'h5C10, cw(1, 8'h5A), "R8");
    cpu_read(16'h5FFF, cw(1, 8'hC3), "R8");

    // R5: video view of aux RAM per mode
    vid_read(14'h2810, vw(0,0,0,10'h0,1,8'h5A), "R5");
    vid_read(14'h2BFF, vw(0,0,0,10'h0,1,8'hC3), "R5");
    cpu_write(A_MODE, 8'h01);
    vid_read(14'h2810, vw(0,0,0,10'h0,1,8'h5A), "R5");
    cpu_write(A_MODE, 8'h02);
    vid_read(14'h2810, vw(0,0,0,10'h0,1,8'h00), "R5");
    cpu_write(A_MODE, 8'h03);
    vid_read(14'h2810, vw(0,0,0,10'h0,1,8'h00), "R5");

    // R6: video writes to aux RAM slot
    cpu_write(A_MODE, 8'h01);
    vid_write(14'h2820, 8'h77, vw(0,0,0,10'h0,0,0), "R6");
    cpu_read(16'h5C20, cw(1, 8'h77), "R6");
    cpu_write(A_MODE, 8'h02);
    vid_write(14'h2821, 8'h66, vw(0,0,0,10'h0,0,0), "R6");
    cpu_read(16'h5C21, cw(1, 8'h11), "R6");

    // R8: CPU write accepted in mode 2, ignored in mode 3
    cpu_write(16'h5C31, 8'h55);
    cpu_read(16'h5C31, cw(1, 8'h55), "R8");
    cpu_write(A_MODE, 8'h03);
    cpu_write(16'h5C30, 8'h99);
    cpu_read(16'h5C30, cw(1, 8'h44), "R8");

    // R3/R4: fill source
    cpu_write(A_TILE, 8'h3B);
    cpu_write(A_COL, 8'hFE);
    vid_read(14'h2C00, vw(0,0,0,10'h0,1,8'h3B), "R3");
    vid_read(14'h2FBF, vw(0,0,0,10'h0,1,8'h3B), "R3");
    vid_read(14'h2FC0, vw(0,0,0,10'h0,1,8'hAA), "R4");
    vid_read(14'h2FFF, vw(0,0,0,10'h0,1,8'hAA), "R4");
    cpu_write(A_COL, 8'h01);
    vid_read(14'h2FD3, vw(0,0,0,10'h0,1,8'h55), "R4");

    // R7: fill writes discarded
    vid_write(14'h2C05, 8'hEE, vw(0,0,0,10'h0,0,0), "R7");
    vid_read(14'h2C05, vw(0,0,0,10'h0,1,8'h3B), "R7");

    // R10: same-cycle remap of slot 0 from page 1 to page 0
    cpu_addr = A_MAP; cpu_wdata = 8'hE0; cpu_wr = 1;
    vid_addr = 14'h2005; vid_rd = 1;
    push(1'b0, vw(0,1,1,10'h005,0,0), "R10");
    finish_cycle();
    vid_read(14'h2005, vw(0,1,0,10'h005,0,0), "R10");

    // R12: reads that hit nothing
    cpu_read(16'h5000, cw(0, 8'h00), "R12");
    cpu_read(A_TILE, cw(0, 8'h00), "R12");

    repeat (2) @(posedge clk);
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    summary();
  end
endmodule